// File: doc/BRIEF.md
# High/Low Count Clock Divider

This block divides a reference clock by an integer ratio from 1 to 128. The ratio is not given as one terminal count. It is given as a high-phase count, a low-phase count, a half-cycle edge flag and a bypass flag, packed into two configuration words. The block runs on a fast system clock. It receives `half_tick`, a one-cycle enable that pulses at twice the reference rate, so each pulse marks half a reference period. It produces a square wave `clk_out` and a one-cycle enable `rise_en` at every rising edge of that wave.

To divide by N > 1, software writes high = floor(N/2), low = N − high and edge = N mod 2. The edge flag moves half a reference period from the low phase into the high phase. Odd ratios therefore still give a 50% duty cycle.

A write is first held in a shadow register. It takes effect only when the next high phase starts, so the phase in progress is never cut short. A readback port reports the divide ratio currently in effect.

Top module: `hl_clock_divider`

## Requirements
- R1: `cfg_word_a` holds the high count in bits 11:6 and the low count in bits 5:0. `cfg_word_b` holds the edge flag in bit 7 and the bypass flag in bit 6. All other bits of `cfg_word_b` are ignored.
- R2: While the bypass flag is set, the block divides by 1, whatever the counts and the edge flag are. The high phase lasts half a reference period and so does the low phase.
- R3: With bypass clear, one output period lasts high + low reference periods.
- R4: With bypass clear, the high phase lasts high reference periods, plus half a period when edge = 1. `clk_out` changes only in the cycle after a `half_tick` pulse.
- R5: A count field of 0 stands for 64.
- R6: `ratio` reports the divide ratio in effect: 1 under bypass, otherwise high + low after R5 is applied. Its value always lies between 1 and 128.
- R7: A word pair loaded with `cfg_load` takes effect only at the start of the next high phase. The period in progress when the load arrives keeps its old length.
- R8: During reset `clk_out` and `rise_en` are low and the bypass (ratio 1) setting is in effect. The first high phase starts on the first `half_tick` after reset is released.
- R9: `rise_en` is high for exactly one cycle, the first cycle in which `clk_out` is high in each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_tick | input | 1 | Enable pulse at twice the reference rate |
| cfg_load | input | 1 | Captures both configuration words into the shadow register |
| cfg_word_a | input | 12 | High count [11:6], low count [5:0] |
| cfg_word_b | input | 8 | Edge flag [7], bypass flag [6] |
| clk_out | output | 1 | Divided square wave |
| rise_en | output | 1 | One-cycle pulse at each rising edge of `clk_out` |
| ratio | output | 8 | Divide ratio in effect |

## Verification
On every cycle, the embedded assertions check four things:
- `clk_out` moves only after a half tick.
- `rise_en` marks exactly a low-to-high change.
- The phase counter stays within its largest legal load.
- The active setting changes only when a high phase starts, and the readback stays within 1 to 128.

The exact period and high time for each ratio can only be shown by the bench's sweep of N from 1 to 128. The same holds for zero fields standing for 64, for bypass overriding the counts, and for a load leaving the running period untouched.

// File: rtl/hl_div_pkg.sv
package hl_div_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  localparam int BYP_POS_DEF = 6;
  localparam int CNT_W_DEF   = 6;
endpackage

// File: rtl/hl_div_shadow.sv
module hl_div_shadow #(
  parameter int CNT_W   = hl_div_pkg::CNT_W_DEF,
  parameter int BYP_POS = hl_div_pkg::BYP_POS_DEF,
  localparam int A_W    = 2 * CNT_W,
  localparam int B_W    = BYP_POS + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [A_W-1:0]   word_a,
  input  logic [B_W-1:0]   word_b,
  input  logic             apply,
  output logic [CNT_W:0]   nxt_hi,
  output logic             nxt_edge,
  output logic             nxt_byp,
  output logic [CNT_W:0]   act_hi,
  output logic [CNT_W:0]   act_lo,
  output logic             act_edge,
  output logic             act_byp
);
  localparam int EDGE_POS = BYP_POS + 1;

  logic [CNT_W-1:0] pend_hi, pend_lo, run_hi, run_lo;
  logic             pend_edge, pend_byp, pend_v;
  logic             run_edge, run_byp;
  logic             unused_b;

  assign unused_b = ^word_b[BYP_POS-1:0];

  function automatic logic [CNT_W:0] widen(input logic [CNT_W-1:0] f);
    return (f == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, f};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_hi   <= '0;
      pend_lo   <= '0;
      pend_edge <= 1'b0;
      pend_byp  <= 1'b0;
      pend_v    <= 1'b0;
    end else begin
      if (apply) pend_v <= 1'b0;
      if (load) begin
        pend_hi   <= word_a[A_W-1:CNT_W];
        pend_lo   <= word_a[CNT_W-1:0];
        pend_edge <= word_b[EDGE_POS];
        pend_byp  <= word_b[BYP_POS];
        pend_v    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_hi   <= CNT_W'(1);
      run_lo   <= CNT_W'(1);
      run_edge <= 1'b0;
      run_byp  <= 1'b1;
    end else if (apply && pend_v) begin
      run_hi   <= pend_hi;
      run_lo   <= pend_lo;
      run_edge <= pend_edge;
      run_byp  <= pend_byp;
    end
  end

  assign act_hi   = widen(run_hi);
  assign act_lo   = widen(run_lo);
  assign act_edge = run_edge;
  assign act_byp  = run_byp;

  assign nxt_hi   = pend_v ? widen(pend_hi) : act_hi;
  assign nxt_edge = pend_v ? pend_edge : run_edge;
  assign nxt_byp  = pend_v ? pend_byp : run_byp;

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable({act_hi, act_lo, act_edge, act_byp}));
endmodule

// File: rtl/hl_div_timer.sv
module hl_div_timer #(
  parameter int CNT_W = hl_div_pkg::CNT_W_DEF,
  localparam int PH_W = CNT_W + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           half_tick,
  input  logic [CNT_W:0] nxt_hi,
  input  logic           nxt_edge,
  input  logic           nxt_byp,
  input  logic [CNT_W:0] act_lo,
  input  logic           act_edge,
  input  logic           act_byp,
  output logic           apply,
  output logic           clk_out,
  output logic           rise_en
);
  import hl_div_pkg::*;

  localparam logic [PH_W-1:0] MAX_LOAD = PH_W'(2 ** (CNT_W + 1));

  phase_e          phase;
  logic [PH_W-1:0] cnt, hi_len, lo_len;
  logic            done;

  assign hi_len = nxt_byp ? PH_W'(1) : ({nxt_hi, 1'b0} + PH_W'(nxt_edge));
  assign lo_len = act_byp ? PH_W'(1) : ({act_lo, 1'b0} - PH_W'(act_edge));
  assign done   = half_tick && (cnt == '0);
  assign apply  = done && (phase == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_LOW;
      cnt     <= '0;
      rise_en <= 1'b0;
    end else begin
      rise_en <= 1'b0;
      if (done) begin
        if (phase == PH_LOW) begin
          phase   <= PH_HIGH;
          cnt     <= hi_len - PH_W'(1);
          rise_en <= 1'b1;
        end else begin
          phase <= PH_LOW;
          cnt   <= lo_len - PH_W'(1);
        end
      end else if (half_tick) begin
        cnt <= cnt - PH_W'(1);
      end
    end
  end

  assign clk_out = (phase == PH_HIGH);

  // R4
  out_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_tick |=> $stable(clk_out));

  // R9
  rise_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_en |-> (clk_out && !$past(clk_out)));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= MAX_LOAD);
endmodule

// File: rtl/hl_div_readback.sv
module hl_div_readback #(
  parameter int CNT_W = hl_div_pkg::CNT_W_DEF,
  localparam int R_W  = CNT_W + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CNT_W:0] act_hi,
  input  logic [CNT_W:0] act_lo,
  input  logic           act_byp,
  output logic [R_W-1:0] ratio
);
  assign ratio = act_byp ? R_W'(1) : ({1'b0, act_hi} + {1'b0, act_lo});

  // R6
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio >= R_W'(1)) && (ratio <= R_W'(2 ** (CNT_W + 1))));
endmodule

// File: rtl/hl_clock_divider.sv
module hl_clock_divider #(
  parameter int CNT_W   = hl_div_pkg::CNT_W_DEF,
  parameter int BYP_POS = hl_div_pkg::BYP_POS_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 half_tick,
  input  logic                 cfg_load,
  input  logic [2*CNT_W-1:0]   cfg_word_a,
  input  logic [BYP_POS+1:0]   cfg_word_b,
  output logic                 clk_out,
  output logic                 rise_en,
  output logic [CNT_W+1:0]     ratio
);
  logic [CNT_W:0] nxt_hi, act_hi, act_lo;
  logic           nxt_edge, nxt_byp, act_edge, act_byp, apply;

  hl_div_shadow #(.CNT_W(CNT_W), .BYP_POS(BYP_POS)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .word_a(cfg_word_a), .word_b(cfg_word_b), .apply(apply),
    .nxt_hi(nxt_hi), .nxt_edge(nxt_edge), .nxt_byp(nxt_byp),
    .act_hi(act_hi), .act_lo(act_lo), .act_edge(act_edge), .act_byp(act_byp)
  );

  hl_div_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
    .nxt_hi(nxt_hi), .nxt_edge(nxt_edge), .nxt_byp(nxt_byp),
    .act_lo(act_lo), .act_edge(act_edge), .act_byp(act_byp),
    .apply(apply), .clk_out(clk_out), .rise_en(rise_en)
  );

  hl_div_readback #(.CNT_W(CNT_W)) u_rb (
    .clk(clk), .rst_n(rst_n), .act_hi(act_hi), .act_lo(act_lo),
    .act_byp(act_byp), .ratio(ratio)
  );

  // R8
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_low_chk: assert (!clk_out && !rise_en);
    end
  end
endmodule

// File: tb/hl_clock_divider_test.sv
module hl_clock_divider_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_tick = 1'b0;
  logic        cfg_load = 1'b0;
  logic [11:0] cfg_word_a = '0;
  logic [7:0]  cfg_word_b = '0;
  logic        clk_out, rise_en;
  logic [7:0]  ratio;

  int cyc = 0;
  int total = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  hl_clock_divider uut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .cfg_load(cfg_load),
    .cfg_word_a(cfg_word_a), .cfg_word_b(cfg_word_b),
    .clk_out(clk_out), .rise_en(rise_en), .ratio(ratio)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) half_tick <= ~half_tick;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_to(input logic lvl, output int t);
    do @(negedge clk); while (clk_out !== lvl);
    t = cyc;
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done_flag) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int t_prev, t1, t2, t3, n, prev_n;
    // R8: reset state
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 out low in reset", clk_out, 0);
      chk("R8 rise low in reset", rise_en, 0);
    end
    chk("R6 R8 reset ratio", ratio, 1);
    rst_n = 1'b1;
    n = 0;
    while (clk_out !== 1'b1 && n < 10) begin
      @(negedge clk);
      n++;
    end
    chk("R8 first high within one half tick", (n >= 1 && n <= 2) ? 1 : 0, 1);
    t_prev = cyc;
    prev_n = 1;

    // sweep N = 1..128 (R1 R2 R3 R4 R5 R6 R7 R9)
    for (int nn = 1; nn <= 128; nn++) begin
      int h, l, e;
      if (nn == 1) begin
        // R2: bypass with nonzero counts and edge set
        cfg_word_a = {6'd5, 6'd7};
        cfg_word_b = 8'b1100_0000;
      end else begin
        h = nn / 2;
        l = nn - h;
        e = nn % 2;
        // R5: a count of 64 is written as field 0
        cfg_word_a = {h[5:0], l[5:0]};
        cfg_word_b = {e[0], 1'b0, 6'b10_1101};
      end
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      wait_to(1'b0, t2);
      wait_to(1'b1, t1);
      // R7: period running at load time keeps the old ratio
      chk($sformatf("R7 old period N=%0d", nn), t1 - t_prev, 4 * prev_n);
      chk($sformatf("R9 rise pulse N=%0d", nn), rise_en, 1);
      @(negedge clk);
      chk($sformatf("R9 rise single N=%0d", nn), rise_en, 0);
      chk($sformatf("R6 ratio N=%0d", nn), ratio, nn);
      wait_to(1'b0, t2);
      chk($sformatf("R4 high time N=%0d", nn), t2 - t1, 2 * nn);
      wait_to(1'b1, t3);
      chk($sformatf("R3 period N=%0d", nn), t3 - t1, 4 * nn);
      t_prev = t3;
      prev_n = nn;
    end

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule